// File: doc/BRIEF.md
# Twisted-Ring Counter with One-Hot State Decoder

This block is a four-stage twisted-ring counter. The inverted output of the last stage feeds the first stage, and every other stage takes the value of the stage before it. The counter therefore steps through eight codes. Each code has a decoded output line. Every line is formed from only two neighbouring stage bits, so the decode never needs the full four-bit compare. The decoded lines are registered and line up with the stage outputs in the same cycle. This keeps them free of glitches.

A synchronous clear returns the counter to its first code. An enable input gates stepping. Eight of the sixteen possible codes are not part of the sequence. If the stages ever hold one of these codes, the counter loads the first code on the next clock, whatever the enable input is doing. The asynchronous-reset code is a parameter. It defaults to the first code, and a non-default value lets a bench start the counter from an upset code.

Top module: `twisted_ring_decoder`

## Requirements
- R1: While rst_ni is low, stage_o takes the value of parameter RST_CODE (default 4'b0000) without waiting for a clock. state_o shows the two-bit decode of that code, which is state_o = 8'b0000_0001 for the default.
- R2: When clr_i is high at a rising clock edge, the next value of stage_o is 4'b0000 and the next value of state_o is 8'b0000_0001. This holds whatever en_i is.
- R3: When en_i is high and clr_i is low, each clock moves stage_o (bit k is stage k) one step through this sequence: 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, and then back to 0000. Written as a formula, the new bit 0 is the inverse of the old bit 3, and the new bit k is the old bit k-1.
- R4: When en_i and clr_i are both low and stage_o holds a code in the sequence, stage_o and state_o do not change.
- R5: state_o bit i is high when the counter holds the i-th code of the R3 list, counted from 0. state_o changes on the same clock edge as stage_o.
- R6: Whenever stage_o holds one of the eight codes in the sequence, exactly one bit of state_o is high.
- R7: If stage_o holds a code that is not in the sequence, the next clock sets stage_o to 4'b0000 and state_o to 8'b0000_0001. This happens even when en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to the first code |
| en_i | input | 1 | Step enable |
| stage_o | output | 4 | Stage outputs, bit k is stage k |
| state_o | output | 8 | Registered one-hot state lines |

## Verification
The bench runs the counter past a full wrap with enable held high. This shows the eight codes in order and tells a wrong feedback polarity apart from a wrong shift direction. A second pattern alternates enable with idle cycles, which separates hold from step. Clears are applied with enable both high and low to show that clear wins. A mid-run reset checks the asynchronous path. Two extra instances are reset to codes outside the sequence with enable tied low. They show that recovery does not wait for enable, and that it lands on the first code rather than on some other code in the sequence.

// File: rtl/twisted_ring_pkg.sv
`timescale 1ns/1ps
package twisted_ring_pkg;

  localparam int unsigned NumStages = 4;
  localparam int unsigned NumStates = 2 * NumStages;

  typedef logic [NumStages-1:0] stage_t;
  typedef logic [NumStates-1:0] state_t;

  // a code belongs to the sequence when adjacent stages differ at most once
  function automatic logic code_valid(input stage_t c);
    int unsigned edges;
    edges = 0;
    for (int k = 1; k < NumStages; k++) begin
      if (c[k] != c[k-1]) edges++;
    end
    return edges <= 1;
  endfunction

  // every state line uses exactly two neighbouring stage bits
  function automatic state_t decode2(input stage_t c);
    state_t d;
    d = '0;
    d[0]         = ~c[0] & ~c[NumStages-1];
    d[NumStages] =  c[0] &  c[NumStages-1];
    for (int k = 1; k < NumStages; k++) begin
      d[k]             =  c[k-1] & ~c[k];
      d[NumStages + k] = ~c[k-1] &  c[k];
    end
    return d;
  endfunction

endpackage

// File: rtl/twisted_ring_chain.sv
`timescale 1ns/1ps
module twisted_ring_chain
  import twisted_ring_pkg::*;
#(
  parameter stage_t RST_CODE = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   en_i,
  output stage_t stage_q_o,
  output stage_t stage_d_o
);

  stage_t stage_q, stage_d;
  logic   valid;

  assign valid = code_valid(stage_q);

  always_comb begin
    stage_d = stage_q;
    if (clr_i || !valid) stage_d = '0;
    else if (en_i)       stage_d = {stage_q[NumStages-2:0], ~stage_q[NumStages-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= RST_CODE;
    else         stage_q <= stage_d;
  end

  assign stage_q_o = stage_q;
  assign stage_d_o = stage_d;

  AST_CLR_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> stage_q == '0); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i && valid) |=> $stable(stage_q)); // R4
  AST_FEEDBACK_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && valid) |=> stage_q[0] != $past(stage_q[NumStages-1])); // R3
  AST_UPSET_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> stage_q == '0); // R7

endmodule

// File: rtl/twisted_ring_decode.sv
`timescale 1ns/1ps
module twisted_ring_decode
  import twisted_ring_pkg::*;
#(
  parameter stage_t RST_CODE = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stage_t stage_d_i,
  output state_t state_q_o
);

  localparam state_t RstState = decode2(RST_CODE);

  state_t state_q;

  // decode the next code so the registered lines align with the stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RstState;
    else         state_q <= decode2(stage_d_i);
  end

  assign state_q_o = state_q;

endmodule

// File: rtl/twisted_ring_decoder.sv
`timescale 1ns/1ps
module twisted_ring_decoder
  import twisted_ring_pkg::*;
#(
  parameter stage_t RST_CODE = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  output logic [3:0] stage_o,
  output logic [7:0] state_o
);

  stage_t stage_q, stage_d;
  state_t state_q;

  twisted_ring_chain #(.RST_CODE(RST_CODE)) i_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .en_i     (en_i),
    .stage_q_o(stage_q),
    .stage_d_o(stage_d)
  );

  twisted_ring_decode #(.RST_CODE(RST_CODE)) i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stage_d_i(stage_d),
    .state_q_o(state_q)
  );

  assign stage_o = stage_q;
  assign state_o = state_q;

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid(stage_o) |-> $onehot(state_o)); // R6
  AST_CLR_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_o == 8'b0000_0001); // R2
  AST_LINE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && code_valid(stage_o)) |=> state_o != $past(state_o)); // R5

endmodule

// File: tb/test_twisted_ring_decoder.sv
`timescale 1ns/1ps
module test_twisted_ring_decoder;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] stage_o, stage5, stage9;
  logic [7:0] state_o, state5, state9;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  int exp_q[$];
  bit done   = 1'b0;

  always #10 clk = ~clk;

  twisted_ring_decoder i_twisted_ring_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(en_i),
    .stage_o(stage_o), .state_o(state_o));

  twisted_ring_decoder #(.RST_CODE(4'b0101)) i_twisted_ring_decoder_u5 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(1'b0), .en_i(1'b0),
    .stage_o(stage5), .state_o(state5));

  twisted_ring_decoder #(.RST_CODE(4'b1001)) i_twisted_ring_decoder_u9 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(1'b0), .en_i(1'b0),
    .stage_o(stage9), .state_o(state9));

  function automatic logic [3:0] code_of(int i);
    logic [3:0] c;
    for (int k = 0; k < 4; k++) c[k] = (i < 4) ? (k < i) : (k >= i - 4);
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit en, bit clr);
    @(negedge clk);
    en_i  = en;
    clr_i = clr;
    if (clr)     idx = 0;
    else if (en) idx = (idx + 1) % 8;
    exp_q.push_back(idx);
  endtask

  // monitor: pops one expected index per clock after the outputs settle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check("R3 stage code", stage_o, code_of(e));
        check("R5 state line", state_o, 8'(1) << e);
        check("R6 one line high", $countones(state_o), 1);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #35;
    check("R1 reset stage", stage_o, 4'b0000);
    check("R1 reset line", state_o, 8'b0000_0001);
    check("R1 reset upset code", stage5, 4'b0101);
    check("R1 reset upset code", stage9, 4'b1001);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #2;
    check("R7 recover en low", stage5, 4'b0000);
    check("R7 recover line", state5, 8'b0000_0001);
    check("R7 recover en low", stage9, 4'b0000);
    check("R7 recover line", state9, 8'b0000_0001);
    @(posedge clk);
    #2;
    check("R4 recovered holds", stage5, 4'b0000);

    // full wrap and beyond
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    // interleaved hold and step
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 1'b0);
    // clear wins over enable, then clear with enable low
    step(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);

    // asynchronous reset mid-run (R1)
    @(negedge clk);
    en_i = 1'b0;
    clr_i = 1'b0;
    @(posedge clk);
    #2;
    @(negedge clk);
    #3;
    rst_ni = 1'b0;
    #1;
    check("R1 async stage", stage_o, 4'b0000);
    check("R1 async line", state_o, 8'b0000_0001);
    @(negedge clk);
    rst_ni = 1'b1;
    idx = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    @(posedge clk);
    #3;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule